// File: doc/BRIEF.md
# Planar Graphics Write Raster-Op Unit

This block stands between a CPU and a bitmap memory that is split into four planes: blue, red, green and intensity. Each memory address holds one byte per plane. Software sets up a small register file through two ports. An index port selects a register and can turn on auto-increment. A data port writes the selected register. The register file holds four per-plane pattern bytes, a color register, a function and plane-enable register, a bit-mask register and a read-select register.

When the CPU writes into the window, the unit first fetches the byte of every plane at that address. It then merges each byte with the CPU data using the selected raster function and writes back only the enabled planes. The two raster functions are REPLACE, which is gated by the bit mask, and PSET, which is gated by the CPU data. When the CPU reads from the window, the unit returns the byte of one chosen plane. In the same response it also returns a per-bit color-compare byte.

A ready output stalls the CPU while an access is in progress. A registered status byte reports the display-active flag and the screen-clear busy flag, both supplied from outside the block.

Top module: `gp_rop_unit`

## Requirements
- R1: After reset, the following hold:
  - every register and the index are zero, with auto-increment off;
  - `acc_rdy` is 1;
  - `mem_rd`, `mem_we`, `mem_wen`, `rd_valid` and `stat_o` are 0.
- R2: Writing the index port (`rf_sel`=0) works as follows:
  - bit 7 sets auto-increment;
  - bits 2:0 choose the register;
  - bits 6:3 are ignored.

  Writing the data port (`rf_sel`=1) stores into the chosen register:
  - registers 0-3 are the B, R, G and I pattern bytes;
  - register 4 holds the color in bits 3:0, ordered {I,G,R,B};
  - register 5 holds the function in bits 5:4 and the plane enables {I,G,R,B} in bits 3:0;
  - register 6 is the bit mask;
  - register 7 holds the direct-read plane in bits 5:4 (0 B, 1 R, 2 G, 3 I) and the compare color {I,G,R,B} in bits 3:0.
- R3: With auto-increment on, each data-port write adds one to the low two bits of the register number, modulo 4. Bit 2 does not change, so 3 wraps to 0 and 7 wraps to 4.
- R4: The memory port follows a fixed sequence:
  - an access is accepted when `acc_req` and `acc_rdy` are both 1 at a clock edge;
  - in the next cycle `mem_rd` is 1 and `mem_addr` equals the access address;
  - in the cycle after that, a write access drives `mem_we`;
  - `acc_rdy` is 0 in both of those cycles and returns to 1 afterwards.
- R5: With function 00 (REPLACE), each enabled plane p is written as (old AND NOT mask) OR (cpu AND pattern[p] AND mask). The OR term is present only when color bit p is 1.
- R6: With function 01 (PSET), each enabled plane p is written as (old AND NOT cpu) OR (cpu AND pattern[p]). The OR term is present only when color bit p is 1.
- R7: During the write cycle, `mem_wen` equals the plane enables, so disabled planes stay unchanged in memory. Plane p occupies `mem_wdata`/`mem_rdata` bits 8p+7:8p, in the order B=0, R=1, G=2, I=3.
- R8: With function 10 or 11, a write access still performs its read phase and keeps the same `acc_rdy` timing. It asserts no `mem_we`, and the memory stays unchanged.
- R9: A read access never asserts `mem_we`. It pulses `rd_valid` for one cycle, two cycles after acceptance. `rd_plane` then carries the byte of the plane selected in register 7.
- R10: With `rd_valid`, bit i of `rd_match` is 1 exactly when, for all four planes p, bit i of plane p equals compare-color bit p.
- R11: The register settings are captured at the edge that accepts an access. A register write in the same cycle, or while the access is busy, affects only later accesses.
- R12: `stat_o` is registered one cycle after its inputs:
  - bit 7 is `disp_active_i` (0 means vertical blanking);
  - bit 6 is `clr_busy_i` (1 means a clear is running);
  - bits 5:0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_wr | input | 1 | Register port write strobe |
| rf_sel | input | 1 | 0 index port, 1 data port |
| rf_wdata | input | 8 | Register port write data |
| disp_active_i | input | 1 | Vertical display-active flag (0 = blanking) |
| clr_busy_i | input | 1 | Screen clear running flag |
| stat_o | output | 8 | Registered status byte |
| acc_req | input | 1 | CPU window access request |
| acc_we | input | 1 | 1 write, 0 read |
| acc_addr | input | AW | Window byte address |
| acc_wdata | input | 8 | CPU write data |
| acc_rdy | output | 1 | Idle and able to accept |
| rd_valid | output | 1 | Read result valid pulse |
| rd_plane | output | 8 | Direct plane read byte |
| rd_match | output | 8 | Color-compare byte |
| mem_addr | output | AW | Plane memory address |
| mem_rd | output | 1 | Plane memory read strobe (data next cycle) |
| mem_we | output | 1 | Plane memory write strobe |
| mem_wen | output | 4 | Per-plane write enables {I,G,R,B} |
| mem_wdata | output | 32 | Four plane bytes to write |
| mem_rdata | input | 32 | Four plane bytes read |

## Verification
Register programming and window accesses can fall in the same cycle. This covers a data-port write at the accepting edge and one in the following busy cycle. The bench provokes the case directly by changing the function from REPLACE to PSET, and then to clear, around a single write access. It also repeats the case randomly throughout the run.

The result is judged in two ways:
- the plane bytes in the bench-owned memory must match the function captured at acceptance;
- the next access must follow the newest setting.

// File: rtl/gp_pkg.sv
package gp_pkg;
    localparam int NPL   = 4;
    localparam int BYTEW = 8;
    localparam int NREG  = 8;
    localparam int RNW   = $clog2(NREG);

    typedef enum logic [1:0] {
        FN_REPLACE = 2'b00,
        FN_PSET    = 2'b01,
        FN_CLEAR   = 2'b10,
        FN_RSVD    = 2'b11
    } rop_fn_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_FETCH  = 2'b01,
        ST_FINISH = 2'b10
    } seq_st_e;

    typedef struct packed {
        logic [NPL-1:0][BYTEW-1:0] pat;
        logic [NPL-1:0]            color;
        rop_fn_e                   fn;
        logic [NPL-1:0]            pen;
        logic [BYTEW-1:0]          mask;
        logic [1:0]                rplane;
        logic [NPL-1:0]            rcolor;
    } ctl_t;

    function automatic logic fn_writes(rop_fn_e f);
        return (f == FN_REPLACE) || (f == FN_PSET);
    endfunction

    function automatic logic [BYTEW-1:0] rop_byte(
        rop_fn_e f, logic [BYTEW-1:0] old, logic [BYTEW-1:0] cpu,
        logic [BYTEW-1:0] pat, logic [BYTEW-1:0] mask, logic cbit);
        logic [BYTEW-1:0] r;
        case (f)
            FN_REPLACE: r = (old & ~mask) | (cbit ? (cpu & pat & mask) : '0);
            FN_PSET:    r = (old & ~cpu)  | (cbit ? (cpu & pat) : '0);
            default:    r = old;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/gp_regfile.sv
module gp_regfile
    import gp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             sel,
    input  logic [BYTEW-1:0] wdata,
    output ctl_t             ctl
);
    logic           auto_q;
    logic [RNW-1:0] num_q;
    ctl_t           ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_q <= 1'b0;
            num_q  <= '0;
            ctl_q  <= '0;
        end else if (wr) begin
            if (!sel) begin
                auto_q <= wdata[7];
                num_q  <= wdata[RNW-1:0];
            end else begin
                if (!num_q[2]) begin
                    ctl_q.pat[num_q[1:0]] <= wdata;
                end else begin
                    case (num_q[1:0])
                        2'd0: ctl_q.color <= wdata[NPL-1:0];
                        2'd1: begin
                            ctl_q.fn  <= rop_fn_e'(wdata[5:4]);
                            ctl_q.pen <= wdata[NPL-1:0];
                        end
                        2'd2: ctl_q.mask <= wdata;
                        default: begin
                            ctl_q.rplane <= wdata[5:4];
                            ctl_q.rcolor <= wdata[NPL-1:0];
                        end
                    endcase
                end
                if (auto_q) num_q[1:0] <= num_q[1:0] + 2'd1;
            end
        end
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/gp_seq.sv
module gp_seq
    import gp_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [BYTEW-1:0] wdata,
    input  ctl_t             ctl_live,
    output logic             idle,
    output logic             fetch,
    output logic             finish,
    output logic             we_q,
    output logic [AW-1:0]    addr_q,
    output logic [BYTEW-1:0] wdata_q,
    output ctl_t             snap
);
    seq_st_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            snap    <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (req) begin
                    st_q    <= ST_FETCH;
                    we_q    <= we;
                    addr_q  <= addr;
                    wdata_q <= wdata;
                    snap    <= ctl_live;
                end
                ST_FETCH: st_q <= ST_FINISH;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    assign idle   = (st_q == ST_IDLE);
    assign fetch  = (st_q == ST_FETCH);
    assign finish = (st_q == ST_FINISH);
endmodule

// File: rtl/gp_rop.sv
module gp_rop
    import gp_pkg::*;
(
    input  logic [NPL*BYTEW-1:0] old_bytes,
    input  logic [BYTEW-1:0]     cpu,
    input  ctl_t                 ctl,
    output logic [NPL*BYTEW-1:0] new_bytes,
    output logic [BYTEW-1:0]     direct,
    output logic [BYTEW-1:0]     match
);
    logic [NPL-1:0][BYTEW-1:0] old_p;
    logic [NPL-1:0][BYTEW-1:0] eq_p;

    assign old_p = old_bytes;

    for (genvar p = 0; p < NPL; p++) begin : g_plane
        assign new_bytes[p*BYTEW +: BYTEW] =
            rop_byte(ctl.fn, old_p[p], cpu, ctl.pat[p], ctl.mask, ctl.color[p]);
        assign eq_p[p] = ~(old_p[p] ^ {BYTEW{ctl.rcolor[p]}});
    end

    assign direct = old_p[ctl.rplane];

    always_comb begin
        match = '1;
        for (int p = 0; p < NPL; p++) match = match & eq_p[p];
    end
endmodule

// File: rtl/gp_rop_unit.sv
module gp_rop_unit
    import gp_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rf_wr,
    input  logic                 rf_sel,
    input  logic [7:0]           rf_wdata,
    input  logic                 disp_active_i,
    input  logic                 clr_busy_i,
    output logic [7:0]           stat_o,
    input  logic                 acc_req,
    input  logic                 acc_we,
    input  logic [AW-1:0]        acc_addr,
    input  logic [7:0]           acc_wdata,
    output logic                 acc_rdy,
    output logic                 rd_valid,
    output logic [7:0]           rd_plane,
    output logic [7:0]           rd_match,
    output logic [AW-1:0]        mem_addr,
    output logic                 mem_rd,
    output logic                 mem_we,
    output logic [3:0]           mem_wen,
    output logic [31:0]          mem_wdata,
    input  logic [31:0]          mem_rdata
);
    ctl_t             ctl_live, snap;
    logic             idle, fetch, finish, we_q;
    logic [BYTEW-1:0] wdata_q, direct, match;
    logic             write_ok;
    logic             rv_q;
    logic [BYTEW-1:0] rp_q, rm_q;
    logic [7:0]       stat_q;

    gp_regfile u_rf (
        .clk(clk), .rst(rst), .wr(rf_wr), .sel(rf_sel),
        .wdata(rf_wdata), .ctl(ctl_live)
    );

    gp_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst(rst), .req(acc_req), .we(acc_we),
        .addr(acc_addr), .wdata(acc_wdata), .ctl_live(ctl_live),
        .idle(idle), .fetch(fetch), .finish(finish), .we_q(we_q),
        .addr_q(mem_addr), .wdata_q(wdata_q), .snap(snap)
    );

    gp_rop u_dp (
        .old_bytes(mem_rdata), .cpu(wdata_q), .ctl(snap),
        .new_bytes(mem_wdata), .direct(direct), .match(match)
    );

    assign write_ok = finish && we_q && fn_writes(snap.fn);
    assign mem_we   = write_ok;
    assign mem_wen  = write_ok ? snap.pen : '0;
    assign mem_rd   = fetch;
    assign acc_rdy  = idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q   <= 1'b0;
            rp_q   <= '0;
            rm_q   <= '0;
            stat_q <= '0;
        end else begin
            rv_q   <= finish && !we_q;
            stat_q <= {disp_active_i, clr_busy_i, 6'b0};
            if (finish && !we_q) begin
                rp_q <= direct;
                rm_q <= match;
            end
        end
    end

    assign rd_valid = rv_q;
    assign rd_plane = rp_q;
    assign rd_match = rm_q;
    assign stat_o   = stat_q;
endmodule

// File: rtl/gp_rop_unit_chk.sv
module gp_rop_unit_chk #(
    parameter int AW = 14
) (
    input logic          clk,
    input logic          rst,
    input logic          rf_wr,
    input logic          rf_sel,
    input logic [7:0]    rf_wdata,
    input logic          disp_active_i,
    input logic          clr_busy_i,
    input logic [7:0]    stat_o,
    input logic          acc_req,
    input logic          acc_we,
    input logic [AW-1:0] acc_addr,
    input logic [7:0]    acc_wdata,
    input logic          acc_rdy,
    input logic          rd_valid,
    input logic [7:0]    rd_plane,
    input logic [7:0]    rd_match,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_we,
    input logic [3:0]    mem_wen,
    input logic [31:0]   mem_wdata,
    input logic [31:0]   mem_rdata
);
    a_r4_accept_fetch: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_rdy) |=> (mem_rd && !acc_rdy));
    a_r4_fetch_then_finish: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (!mem_rd && !acc_rdy));
    a_r4_addr_held: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> $stable(mem_addr));
    a_r4_we_after_fetch: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(mem_rd));
    a_r4_we_then_idle: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> acc_rdy);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        acc_rdy |-> (!mem_rd && !mem_we));
    a_r7_wen_only_in_write: assert property (@(posedge clk) disable iff (rst)
        !mem_we |-> (mem_wen == 4'b0000));
    a_r9_rvalid_after_fetch: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(!mem_rd) && !mem_we && acc_rdy));
    a_r9_rvalid_single: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
    a_r12_stat_reserved: assert property (@(posedge clk) disable iff (rst)
        stat_o[5:0] == 6'b0);
endmodule

bind gp_rop_unit gp_rop_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/gp_rop_unit_bench.sv
module gp_rop_unit_bench;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rf_wr = 1'b0, rf_sel = 1'b0;
    logic [7:0]    rf_wdata = '0;
    logic          disp_active_i = 1'b0, clr_busy_i = 1'b0;
    logic [7:0]    stat_o;
    logic          acc_req = 1'b0, acc_we = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [7:0]    acc_wdata = '0;
    logic          acc_rdy, rd_valid;
    logic [7:0]    rd_plane, rd_match;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_we;
    logic [3:0]    mem_wen;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;

    always #10 clk = ~clk;

    gp_rop_unit #(.AW(AW)) u_gp_rop_unit (.*);

    logic [31:0] vmem [16];
    logic [31:0] emem [16];

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= vmem[mem_addr[3:0]];
        if (mem_we)
            for (int p = 0; p < 4; p++)
                if (mem_wen[p]) vmem[mem_addr[3:0]][p*8 +: 8] <= mem_wdata[p*8 +: 8];
    end

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    bit        sh_auto;
    logic [2:0] sh_num;
    logic [7:0] sh_pat [4];
    logic [3:0] sh_col, sh_en, sh_rc;
    logic [1:0] sh_fn, sh_rp;
    logic [7:0] sh_mask;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sh_apply(input bit sel, input logic [7:0] d);
        if (!sel) begin
            sh_auto = d[7];
            sh_num  = d[2:0];
        end else begin
            case (sh_num)
                3'd0, 3'd1, 3'd2, 3'd3: sh_pat[sh_num[1:0]] = d;
                3'd4: sh_col = d[3:0];
                3'd5: begin sh_fn = d[5:4]; sh_en = d[3:0]; end
                3'd6: sh_mask = d;
                default: begin sh_rp = d[5:4]; sh_rc = d[3:0]; end
            endcase
            if (sh_auto) sh_num[1:0] = sh_num[1:0] + 2'd1;
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [1:0] f, input logic [7:0] o,
        input logic [7:0] c, input logic [7:0] pt, input logic [7:0] m, input bit cb);
        if (f == 2'b00) return (o & ~m) | (cb ? (c & pt & m) : 8'h00);
        if (f == 2'b01) return (o & ~c) | (cb ? (c & pt) : 8'h00);
        return o;
    endfunction

    function automatic logic [7:0] exp_match(input logic [31:0] w, input logic [3:0] col);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = 1'b1;
            for (int p = 0; p < 4; p++)
                if (w[p*8 + i] != col[p]) r[i] = 1'b0;
        end
        return r;
    endfunction

    // called just after a negedge, returns just after a negedge
    task automatic rf_write(input bit sel, input logic [7:0] d);
        rf_wr = 1'b1; rf_sel = sel; rf_wdata = d;
        @(posedge clk);
        @(negedge clk);
        rf_wr = 1'b0;
        sh_apply(sel, d);
    endtask

    task automatic access(input bit we, input logic [3:0] a, input logic [7:0] d, input string tag,
                          input bit rfa, input logic [7:0] rfa_d, input bit rfb, input logic [7:0] rfb_d);
        logic [31:0] e_word;
        logic [1:0]  fn_c;
        logic [3:0]  en_c;
        bit          wr_c;
        fn_c = sh_fn; en_c = sh_en;
        wr_c = we && (sh_fn < 2'd2);
        e_word = emem[a];
        if (we && wr_c)
            for (int p = 0; p < 4; p++)
                if (sh_en[p]) e_word[p*8 +: 8] = exp_byte(sh_fn, emem[a][p*8 +: 8], d, sh_pat[p], sh_mask, sh_col[p]);
        acc_req = 1'b1; acc_we = we; acc_addr = AW'(a); acc_wdata = d;
        if (rfa) begin rf_wr = 1'b1; rf_sel = 1'b1; rf_wdata = rfa_d; end
        @(posedge clk);
        @(negedge clk);
        acc_req = 1'b0; rf_wr = 1'b0;
        chk(mem_rd == 1'b1 && acc_rdy == 1'b0, "R4 fetch phase", {30'd0, mem_rd, acc_rdy}, 32'h2);
        chk(mem_addr == AW'(a), "R4 fetch address", 32'(mem_addr), 32'(a));
        if (rfb) begin rf_wr = 1'b1; rf_sel = 1'b1; rf_wdata = rfb_d; end
        @(posedge clk);
        @(negedge clk);
        rf_wr = 1'b0;
        chk(mem_we == wr_c, wr_c ? "R4 write phase" : "R8/R9 no write strobe", 32'(mem_we), 32'(wr_c));
        chk(mem_wen == (wr_c ? en_c : 4'h0), "R7 plane enables", 32'(mem_wen), 32'(wr_c ? en_c : 4'h0));
        chk(acc_rdy == 1'b0, "R4 busy in second phase", 32'(acc_rdy), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk(acc_rdy == 1'b1, "R4 ready after access", 32'(acc_rdy), 32'h1);
        if (we) begin
            chk(vmem[a] == e_word, tag, vmem[a], e_word);
            emem[a] = e_word;
        end else begin
            chk(rd_valid == 1'b1, "R9 read valid", 32'(rd_valid), 32'h1);
            chk(rd_plane == emem[a][sh_rp*8 +: 8], "R9 direct plane", 32'(rd_plane), 32'(emem[a][sh_rp*8 +: 8]));
            chk(rd_match == exp_match(emem[a], sh_rc), "R10 color compare", 32'(rd_match), 32'(exp_match(emem[a], sh_rc)));
        end
        if (rfa) sh_apply(1'b1, rfa_d);
        if (rfb) sh_apply(1'b1, rfb_d);
        if (fn_c == 2'b11) n_chk = n_chk + 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R4 actual=%h expected=%h", 0, 1);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        sh_auto = 0; sh_num = 0; sh_col = 0; sh_en = 0; sh_rc = 0;
        sh_fn = 0; sh_rp = 0; sh_mask = 0;
        for (int p = 0; p < 4; p++) sh_pat[p] = 8'h00;
        for (int i = 0; i < 16; i++) begin
            vmem[i] = $urandom;
            emem[i] = vmem[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(acc_rdy == 1'b1 && !mem_rd && !mem_we && mem_wen == 4'h0 && !rd_valid, "R1 idle outputs",
            {27'd0, acc_rdy, mem_rd, mem_we, rd_valid, |mem_wen}, 32'h10);
        chk(stat_o == 8'h00, "R1 status cleared", 32'(stat_o), 32'h0);
        access(1'b0, 4'd0, 8'h00, "R1", 1'b0, 8'h00, 1'b0, 8'h00);
        // R12 status
        disp_active_i = 1'b1; clr_busy_i = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(stat_o == 8'hC0, "R12 status flags", 32'(stat_o), 32'hC0);
        disp_active_i = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(stat_o == 8'h40, "R12 blanking flag", 32'(stat_o), 32'h40);
        // R2 R3 pattern load with auto-increment wrap 3 -> 0
        rf_write(1'b0, 8'h80);
        rf_write(1'b1, 8'h11); rf_write(1'b1, 8'h22);
        rf_write(1'b1, 8'h33); rf_write(1'b1, 8'h44);
        rf_write(1'b1, 8'h5A);
        rf_write(1'b0, 8'h04); rf_write(1'b1, 8'h0F);
        rf_write(1'b0, 8'h05); rf_write(1'b1, 8'h0F);
        rf_write(1'b0, 8'h06); rf_write(1'b1, 8'hF0);
        access(1'b1, 4'd1, 8'hFF, "R3 R5 replace after wrap", 1'b0, 8'h00, 1'b0, 8'h00);
        // R2 ignored index bits, R3 wrap 7 -> 4
        rf_write(1'b0, 8'hFF);
        rf_write(1'b1, 8'h20);
        rf_write(1'b1, 8'h05);
        access(1'b1, 4'd2, 8'hC3, "R2 R5 color via wrapped index", 1'b0, 8'h00, 1'b0, 8'h00);
        access(1'b0, 4'd2, 8'h00, "R9", 1'b0, 8'h00, 1'b0, 8'h00);
        // R6 PSET with partial plane enable
        rf_write(1'b0, 8'h05); rf_write(1'b1, 8'h1A);
        access(1'b1, 4'd3, 8'h3C, "R6 R7 pset partial planes", 1'b0, 8'h00, 1'b0, 8'h00);
        // R8 clear and reserved functions write nothing
        rf_write(1'b1, 8'h2F);
        access(1'b1, 4'd4, 8'hAA, "R8 clear function no write", 1'b0, 8'h00, 1'b0, 8'h00);
        rf_write(1'b1, 8'h3F);
        access(1'b1, 4'd4, 8'h55, "R8 reserved function no write", 1'b0, 8'h00, 1'b0, 8'h00);
        // R11 register writes at accept edge and during busy
        rf_write(1'b1, 8'h0F);
        access(1'b1, 4'd5, 8'h96, "R11 replace kept despite same-cycle change", 1'b1, 8'h1F, 1'b1, 8'h2F);
        access(1'b1, 4'd6, 8'h69, "R11 newest setting applies next", 1'b0, 8'h00, 1'b0, 8'h00);
        // R10 compare on each plane select
        for (int k = 0; k < 4; k++) begin
            rf_write(1'b0, 8'h07);
            rf_write(1'b1, {2'b00, 2'(k), 4'(k * 5)});
            access(1'b0, 4'(k + 7), 8'h00, "R9", 1'b0, 8'h00, 1'b0, 8'h00);
        end
        // random mix
        for (int it = 0; it < 400; it++) begin
            int c;
            c = $urandom_range(0, 9);
            if (c < 4) begin
                rf_write(1'b0, {1'b0, 4'($urandom), 3'($urandom)});
                rf_write(1'b1, 8'($urandom));
            end else begin
                bit rw;
                rw = (c < 8);
                access(rw, 4'($urandom), 8'($urandom),
                       (sh_fn == 2'b00) ? "R5 random" : (sh_fn == 2'b01) ? "R6 random" : "R8 random",
                       ($urandom_range(0, 3) == 0), 8'($urandom),
                       ($urandom_range(0, 3) == 0), 8'($urandom));
            end
        end
        done = 1'b1;
        finish_run();
    end
endmodule